// File: doc/BRIEF.md
# Word-to-Pixel Byte Repacker

This block sits between a word-wide pixel buffer and a display output stage. Upstream it takes bus words of 4 or 8 bytes through a valid/ready handshake. Downstream it hands out one 24-bit colour pixel per clock whenever the timing logic raises a pixel request during active video. Because a word's width is not a multiple of three bytes, pixels regularly straddle word boundaries. The block stores incoming bytes in a small circular byte store with its own write and read pointers. Pixels are cut from that store strictly in arrival order.

The store is sized to the least common multiple of the word width and the pixel width. That is 12 bytes for 4-byte words and 24 bytes for 8-byte words. As a result, the write pointer always lands on a word boundary and the read pointer always lands on a pixel boundary, so neither a word write nor a pixel read ever wraps mid-access. A synchronous frame clear discards everything held so that each frame starts empty. A request that finds fewer than three bytes yields a black pixel and a one-cycle underrun pulse.

Top module: `pixel_repacker`

## Requirements
- R1: The store holds 3*WORD_BYTES bytes (12 for WORD_BYTES=4, 24 for WORD_BYTES=8), and that many bytes can be accepted before any pixel is taken.
- R2: `in_ready` is high exactly when `frame_clr` is low and the free byte count is at least WORD_BYTES. A word is taken on a cycle with `in_valid` and `in_ready` both high.
- R3: The stored byte count never exceeds the store size.
- R4: Byte k of an input word is `in_data[8k+7:8k]`, and a lower k is earlier in the byte stream.
- R5: Each pixel takes three consecutive stream bytes: the earliest goes to `pix_rgb[23:16]` (red), the next to `pix_rgb[15:8]` (green), and the last to `pix_rgb[7:0]` (blue).
- R6: A request seen at a clock edge while at least 3 bytes are stored removes 3 bytes and shows the pixel on `pix_rgb` after that edge. Without a request, `pix_rgb` holds its value.
- R7: A request seen while fewer than 3 bytes are stored sets `pix_rgb` to zero and raises `underrun` for one cycle, and it removes no bytes.
- R8: `frame_clr` empties the store and returns both pointers to zero at the next edge. During that cycle, `in_ready` is low and the outputs go to zero with no underrun.
- R9: A word accept and a pixel removal in the same cycle both take effect. The pixel check uses the count before that cycle's word is added.
- R10: After reset, the store is empty, `in_ready` is high, and `pix_rgb` and `underrun` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clr | input | 1 | Synchronous clear at frame start |
| in_data | input | 8*WORD_BYTES | Input word, byte 0 earliest |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Room for one more word |
| pix_req | input | 1 | Pixel wanted this cycle |
| pix_rgb | output | 24 | Red, green, blue of the last pixel |
| underrun | output | 1 | Request found fewer than 3 bytes |

## Verification
The hardest case to reach is a pixel whose bytes come from two words at the moment the pointers wrap. Another is a request that arrives in the same cycle as the word that would have satisfied it. Random stimulus keeps the input valid and the pixel request independently toggling for thousands of cycles, so the fill level drifts across the full range, including 1 and 2 bytes. Directed sequences add a full-store stall, an empty-store request, a combined accept and emit at 4 bytes, and a mid-stream clear. A byte-queue model in the bench predicts every pixel.

// File: rtl/repack_pkg.sv
package repack_pkg;
    localparam int PIX_BYTES = 3;

    function automatic int gcd_of(input int a, input int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int ring_size(input int word_bytes);
        return (word_bytes * PIX_BYTES) / gcd_of(word_bytes, PIX_BYTES);
    endfunction
endpackage

// File: rtl/repack_ctrl.sv
module repack_ctrl
    import repack_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    parameter int RING       = 12,
    parameter int PW         = 4,
    parameter int CW         = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_clr,
    input  logic          in_valid,
    input  logic          pix_req,
    output logic          in_ready,
    output logic          wr_en,
    output logic          rd_en,
    output logic          starve,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr
);
    localparam logic [CW-1:0] FILL_LIMIT = CW'(RING - WORD_BYTES);
    localparam logic [CW-1:0] WORD_CNT   = CW'(WORD_BYTES);
    localparam logic [CW-1:0] PIX_CNT    = CW'(PIX_BYTES);
    localparam logic [CW-1:0] RING_CNT   = CW'(RING);
    localparam logic [PW-1:0] LAST_WR    = PW'(RING - WORD_BYTES);
    localparam logic [PW-1:0] LAST_RD    = PW'(RING - PIX_BYTES);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        in_ready = !frame_clr && (st_q.cnt <= FILL_LIMIT);
        wr_en    = in_valid && in_ready;
        rd_en    = !frame_clr && pix_req && (st_q.cnt >= PIX_CNT);
        starve   = !frame_clr && pix_req && (st_q.cnt < PIX_CNT);
        st_d     = st_q;
        if (frame_clr) begin
            st_d = '0;
        end else begin
            if (wr_en) begin
                st_d.wr = (st_q.wr == LAST_WR) ? '0 : st_q.wr + PW'(WORD_BYTES);
            end
            if (rd_en) begin
                st_d.rd = (st_q.rd == LAST_RD) ? '0 : st_q.rd + PW'(PIX_BYTES);
            end
            st_d.cnt = st_q.cnt + (wr_en ? WORD_CNT : '0) - (rd_en ? PIX_CNT : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr = st_q.wr;
    assign rd_ptr = st_q.rd;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= RING_CNT);
    p_ready_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (st_q.cnt + WORD_CNT <= RING_CNT));
    p_clear_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_clr |=> (st_q.cnt == '0 && st_q.wr == '0 && st_q.rd == '0));
    p_rd_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rd % PW'(PIX_BYTES)) == '0);
endmodule

// File: rtl/repack_ring.sv
module repack_ring
    import repack_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    parameter int RING       = 12,
    parameter int PW         = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [PW-1:0]           wr_ptr,
    input  logic [8*WORD_BYTES-1:0] wr_word,
    input  logic [PW-1:0]           rd_ptr,
    output logic [8*PIX_BYTES-1:0]  rd_bytes
);
    logic [7:0] mem_d [RING];
    logic [7:0] mem_q [RING];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            for (int i = 0; i < WORD_BYTES; i++) begin
                mem_d[wr_ptr + PW'(i)] = wr_word[8*i +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RING; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    // earliest byte lands in the most significant lane
    for (genvar k = 0; k < PIX_BYTES; k++) begin : g_lane
        logic [PW-1:0] addr;
        assign addr = rd_ptr + PW'(k);
        assign rd_bytes[8*(PIX_BYTES-1-k) +: 8] = mem_q[addr];
    end

    p_wr_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_ptr % PW'(WORD_BYTES)) == '0));
endmodule

// File: rtl/pixel_repacker.sv
module pixel_repacker
    import repack_pkg::*;
#(
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_clr,
    input  logic [8*WORD_BYTES-1:0] in_data,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    pix_req,
    output logic [23:0]             pix_rgb,
    output logic                    underrun
);
    localparam int RING = ring_size(WORD_BYTES);
    localparam int PW   = $clog2(RING);
    localparam int CW   = $clog2(RING + 1);

    typedef struct packed {
        logic [23:0] rgb;
        logic        under;
    } out_t;

    logic          wr_en, rd_en, starve;
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [23:0]   rd_bytes;
    out_t          out_d, out_q;

    repack_ctrl #(
        .WORD_BYTES(WORD_BYTES), .RING(RING), .PW(PW), .CW(CW)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_clr(frame_clr),
        .in_valid(in_valid), .pix_req(pix_req), .in_ready(in_ready),
        .wr_en(wr_en), .rd_en(rd_en), .starve(starve),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
    );

    repack_ring #(
        .WORD_BYTES(WORD_BYTES), .RING(RING), .PW(PW)
    ) i_ring (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr),
        .wr_word(in_data), .rd_ptr(rd_ptr), .rd_bytes(rd_bytes)
    );

    always_comb begin
        out_d       = out_q;
        out_d.under = 1'b0;
        if (frame_clr) begin
            out_d = '0;
        end else if (rd_en) begin
            out_d.rgb = rd_bytes;
        end else if (starve) begin
            out_d.rgb   = '0;
            out_d.under = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pix_rgb  = out_q.rgb;
    assign underrun = out_q.under;

    p_underrun_black_r7: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (pix_rgb == '0));
    p_underrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_req && !frame_clr && !$rose(underrun) && !starve) |=> !underrun);
    p_clear_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_clr |=> (!underrun && pix_rgb == '0));
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_req && !frame_clr) |=> $stable(pix_rgb));
endmodule

// File: tb/test_pixel_repacker.sv
module test_pixel_repacker;
    localparam int W        = 4;
    localparam int RING     = 12;
    localparam int CLK_HALF = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            frame_clr = 1'b0;
    logic [8*W-1:0]  in_data = '0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic            pix_req = 1'b0;
    logic [23:0]     pix_rgb;
    logic            underrun;

    int total = 0;
    int bad = 0;
    logic [7:0]  q[$];
    logic [23:0] exp_rgb = '0;
    logic        exp_under = 1'b0;

    always #CLK_HALF clk = ~clk;

    pixel_repacker #(.WORD_BYTES(W)) i_pixel_repacker (
        .clk(clk), .rst_n(rst_n), .frame_clr(frame_clr),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .pix_req(pix_req), .pix_rgb(pix_rgb), .underrun(underrun)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic v, input logic [8*W-1:0] d, input logic rq,
                        input logic cl, input string tag);
        logic exp_ready;
        @(negedge clk);
        in_valid = v; in_data = d; pix_req = rq; frame_clr = cl;
        #1;
        exp_ready = !cl && ((RING - q.size()) >= W);
        check({tag, " in_ready"}, 32'(in_ready), 32'(exp_ready));
        exp_under = 1'b0;
        if (cl) begin
            q.delete();
            exp_rgb = '0;
        end else begin
            if (rq) begin
                if (q.size() >= 3) begin
                    exp_rgb[23:16] = q.pop_front();
                    exp_rgb[15:8]  = q.pop_front();
                    exp_rgb[7:0]   = q.pop_front();
                end else begin
                    exp_rgb = '0;
                    exp_under = 1'b1;
                end
            end
            if (v && exp_ready) begin
                for (int k = 0; k < W; k++) q.push_back(d[8*k +: 8]);
            end
        end
        @(posedge clk); #1;
        check({tag, " pix_rgb"}, 32'(pix_rgb), 32'(exp_rgb));
        check({tag, " underrun"}, 32'(underrun), 32'(exp_under));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        // R10: reset state
        check("R10 in_ready", 32'(in_ready), 32'd1);
        check("R10 pix_rgb", 32'(pix_rgb), 32'd0);
        check("R10 underrun", 32'(underrun), 32'd0);

        // R1: fill the whole store, then R2: next word refused
        step(1'b1, 32'h03020100, 1'b0, 1'b0, "R1");
        step(1'b1, 32'h07060504, 1'b0, 1'b0, "R1");
        step(1'b1, 32'h0b0a0908, 1'b0, 1'b0, "R1");
        step(1'b1, 32'hdeadbeef, 1'b0, 1'b0, "R2");
        // R4/R5: drain in byte order, pixels spanning words
        step(1'b0, '0, 1'b1, 1'b0, "R5");
        step(1'b0, '0, 1'b1, 1'b0, "R4");
        step(1'b0, '0, 1'b0, 1'b0, "R6");
        step(1'b0, '0, 1'b1, 1'b0, "R4");
        step(1'b0, '0, 1'b1, 1'b0, "R5");
        // R7: empty request
        step(1'b0, '0, 1'b1, 1'b0, "R7");
        step(1'b0, '0, 1'b0, 1'b0, "R7");
        // R9: 4 stored, accept and emit together
        step(1'b1, 32'h44332211, 1'b0, 1'b0, "R9");
        step(1'b1, 32'h88776655, 1'b1, 1'b0, "R9");
        step(1'b0, '0, 1'b1, 1'b0, "R9");
        // R7 with a word arriving the same cycle
        step(1'b1, 32'hccbbaa99, 1'b1, 1'b0, "R7");
        // R8: clear mid-stream
        step(1'b1, 32'h12345678, 1'b1, 1'b1, "R8");
        step(1'b0, '0, 1'b1, 1'b0, "R8");

        // R3/R6: random traffic
        for (int n = 0; n < 3000; n++) begin
            step(($urandom % 10) < 7, $urandom, ($urandom % 2) == 1,
                 ($urandom % 100) == 0, "R3/R6");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule